// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits between an interrupt controller's priority arbiter and the processor's acknowledge strobe. It counts the processor's two acknowledge pulses. On the first pulse it latches the level the arbiter has picked and sends a one-cycle commit pulse, which the in-service and pending logic use. On the second pulse it places an 8-bit vector on the data bus. The vector is a programmable 5-bit base joined to the 3-bit serviced level.

Several controllers can be chained. A controller set up as the master carries a configuration byte with one flag per input, marking the inputs that have a downstream controller attached. When the winning input carries that flag, the master puts the input number on a 3-wire cascade identification bus and stays off the data bus. A controller set up as downstream holds its own 3-bit identity in the low bits of its configuration byte. It drives its vector only when the cascade bus carries that identity during the second pulse.

Top module: `irq_ack_vector`

## Requirements
- R1: The first rising edge of `iack` after idle produces exactly one `commit` pulse one cycle long. In that cycle `commit_lvl` shows the level captured from `pend_level`. Holding `iack` high for longer produces no further pulse.
- R2: If `pend_valid` is low when the first pulse is sampled, the captured level is 7.
- R3: On the second rising edge of `iack`, a driving controller presents `data_out = {vec_base, level}`, with the base in bits 7:3 and the level in bits 2:0. For example, base 5'b00001 with level 3 gives 0x0B.
- R4: `data_oe` is high only from the cycle after the second pulse is sampled until the cycle after `iack` is sampled low. While `data_oe` is low, `data_out` is zero.
- R5: For a master (`is_master`=1) whose winning level L has `cfg_byte[L]`=1, the block drives `cas_oe`=1 and `cas_out`=L from the cycle after the first pulse until the second pulse ends. It keeps `data_oe` low throughout.
- R6: For a master whose winning level has its configuration flag clear, `cas_oe` stays low and the master drives the vector itself.
- R7: A downstream controller (`is_master`=0) drives the vector when `cas_in` equals `cfg_byte[2:0]` while the second pulse is sampled. For example, base 5'b01110 with level 2 gives 0x72.
- R8: A downstream controller whose identity differs from `cas_in` keeps `data_oe` low and `data_out` zero.
- R9: After reset, `commit`, `commit_lvl`, `data_oe`, `data_out`, `cas_oe` and `cas_out` are all zero.
- R10: Changes on `pend_level` and `pend_valid` after the first pulse do not alter the level used in the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iack | input | 1 | Acknowledge strobe from the processor, active high |
| pend_valid | input | 1 | Arbiter has a pending request |
| pend_level | input | 3 | Level selected by the arbiter |
| vec_base | input | 5 | Programmed upper vector bits |
| is_master | input | 1 | 1 = master, 0 = downstream controller |
| cfg_byte | input | 8 | Master: attached-controller flags; downstream: identity in bits 2:0 |
| cas_in | input | 3 | Cascade identification bus as seen by a downstream controller |
| commit | output | 1 | One-cycle in-service commit pulse |
| commit_lvl | output | 3 | Level committed in the current sequence |
| data_out | output | 8 | Vector for the data bus |
| data_oe | output | 1 | Data bus drive enable |
| cas_out | output | 3 | Cascade identity driven by a master |
| cas_oe | output | 1 | Cascade bus drive enable |

## Verification
Two functions can meet in one cycle: the arbiter updates its selected level, and the first acknowledge pulse is sampled. The bench sets up a level and raises the strobe. Right after the commit it changes `pend_level` and `pend_valid`, and it holds the first pulse several cycles, which tests that later changes are ignored. The committed level must match the value present at the sampling edge. The vector of the second pulse must carry that same level, and only one commit pulse may appear.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_DRIVE = 2'd2
  } ack_phase_e;
endpackage

// File: rtl/iack_phase_fsm.sv
module iack_phase_fsm
  import ivs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic iack,
  output logic first_evt,
  output logic second_evt,
  output logic drive_end
);
  logic       iack_q;
  logic       rise;
  ack_phase_e ph_q, ph_d;

  assign rise = iack & ~iack_q;

  always_comb begin
    ph_d       = ph_q;
    first_evt  = 1'b0;
    second_evt = 1'b0;
    drive_end  = 1'b0;
    case (ph_q)
      PH_IDLE:  if (rise) begin ph_d = PH_ARMED; first_evt = 1'b1; end
      PH_ARMED: if (rise) begin ph_d = PH_DRIVE; second_evt = 1'b1; end
      PH_DRIVE: if (!iack) begin ph_d = PH_IDLE; drive_end = 1'b1; end
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iack_q <= 1'b0;
      ph_q   <= PH_IDLE;
    end else begin
      iack_q <= iack;
      ph_q   <= ph_d;
    end
  end
endmodule

// File: rtl/casc_route.sv
module casc_route #(
  parameter int LVL_W = 3,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic             is_master,
  input  logic [NLVL-1:0]  cfg_byte,
  input  logic [LVL_W-1:0] lvl_next,
  input  logic [LVL_W-1:0] lvl_cur,
  input  logic [LVL_W-1:0] cas_in,
  output logic             casc_next,
  output logic             self_drive
);
  always_comb begin
    casc_next = is_master & cfg_byte[lvl_next];
    if (is_master) self_drive = ~cfg_byte[lvl_cur];
    else           self_drive = (cas_in == cfg_byte[LVL_W-1:0]);
  end
endmodule

// File: rtl/vec_stage.sv
module vec_stage #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_evt,
  input  logic              second_evt,
  input  logic              drive_end,
  input  logic [LVL_W-1:0]  lvl_next,
  input  logic              casc_next,
  input  logic              self_drive,
  input  logic [BASE_W-1:0] vec_base,
  output logic [LVL_W-1:0]  lvl_q,
  output logic              commit_q,
  output logic              cas_oe_q,
  output logic              oe_q,
  output logic [VEC_W-1:0]  data_q
);
  logic [LVL_W-1:0] lvl_d;
  logic             commit_d, cas_oe_d, oe_d;
  logic [VEC_W-1:0] data_d;

  always_comb begin
    lvl_d    = first_evt ? lvl_next : lvl_q;
    commit_d = first_evt;
    cas_oe_d = cas_oe_q;
    oe_d     = oe_q;
    data_d   = data_q;
    if (first_evt) cas_oe_d = casc_next;
    if (second_evt) begin
      oe_d   = self_drive;
      data_d = self_drive ? {vec_base, lvl_q} : '0;
    end
    if (drive_end) begin
      cas_oe_d = 1'b0;
      oe_d     = 1'b0;
      data_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      commit_q <= 1'b0;
      cas_oe_q <= 1'b0;
      oe_q     <= 1'b0;
      data_q   <= '0;
    end else begin
      lvl_q    <= lvl_d;
      commit_q <= commit_d;
      cas_oe_q <= cas_oe_d;
      oe_q     <= oe_d;
      data_q   <= data_d;
    end
  end
endmodule

// File: rtl/irq_ack_vector.sv
module irq_ack_vector #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  localparam int BASE_W = VEC_W - LVL_W,
  localparam int NLVL   = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack,
  input  logic              pend_valid,
  input  logic [LVL_W-1:0]  pend_level,
  input  logic [BASE_W-1:0] vec_base,
  input  logic              is_master,
  input  logic [NLVL-1:0]   cfg_byte,
  input  logic [LVL_W-1:0]  cas_in,
  output logic              commit,
  output logic [LVL_W-1:0]  commit_lvl,
  output logic [VEC_W-1:0]  data_out,
  output logic              data_oe,
  output logic [LVL_W-1:0]  cas_out,
  output logic              cas_oe
);
  localparam logic [LVL_W-1:0] DFLT_LVL = LVL_W'(NLVL - 1);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             first_evt, second_evt, drive_end;
  logic [LVL_W-1:0] lvl_next, lvl_q;
  logic             casc_next, self_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign lvl_next = pend_valid ? pend_level : DFLT_LVL;

  iack_phase_fsm u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .iack       (iack),
    .first_evt  (first_evt),
    .second_evt (second_evt),
    .drive_end  (drive_end)
  );

  casc_route #(.LVL_W(LVL_W)) u_route (
    .is_master  (is_master),
    .cfg_byte   (cfg_byte),
    .lvl_next   (lvl_next),
    .lvl_cur    (lvl_q),
    .cas_in     (cas_in),
    .casc_next  (casc_next),
    .self_drive (self_drive)
  );

  vec_stage #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_vec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .first_evt  (first_evt),
    .second_evt (second_evt),
    .drive_end  (drive_end),
    .lvl_next   (lvl_next),
    .casc_next  (casc_next),
    .self_drive (self_drive),
    .vec_base   (vec_base),
    .lvl_q      (lvl_q),
    .commit_q   (commit),
    .cas_oe_q   (cas_oe),
    .oe_q       (data_oe),
    .data_q     (data_out)
  );

  assign commit_lvl = lvl_q;
  assign cas_out    = cas_oe ? lvl_q : '0;
endmodule

// File: rtl/irq_ack_vector_check.sv
module irq_ack_vector_check (
  input logic       clk,
  input logic       rst_n,
  input logic       iack,
  input logic       is_master,
  input logic       commit,
  input logic [2:0] commit_lvl,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic       cas_oe
);
  a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  a_r1_commit_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(iack));

  a_r4_oe_within_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(iack));

  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == 8'h00);

  a_r3_vector_level: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> data_out[2:0] == commit_lvl);

  a_r5_no_dual_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |-> (is_master && !data_oe));
endmodule

bind irq_ack_vector irq_ack_vector_check u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iack       (iack),
  .is_master  (is_master),
  .commit     (commit),
  .commit_lvl (commit_lvl),
  .data_out   (data_out),
  .data_oe    (data_oe),
  .cas_oe     (cas_oe)
);

// File: tb/irq_ack_vector_bench.sv
module irq_ack_vector_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       iack, pend_valid, is_master;
  logic [2:0] pend_level, cas_in;
  logic [4:0] vec_base;
  logic [7:0] cfg_byte;
  logic       commit, data_oe, cas_oe;
  logic [2:0] commit_lvl, cas_out;
  logic [7:0] data_out;

  int tests = 0;
  int fails = 0;

  logic       o_commit, o_extra, o_cas_oe, o_oe, o_oe_hold, o_oe_after, o_cas_after;
  logic [2:0] o_lvl, o_cas;
  logic [7:0] o_data, o_data_after;

  always #2 clk = ~clk;

  irq_ack_vector u_irq_ack_vector (
    .clk(clk), .rst_n(rst_n), .iack(iack), .pend_valid(pend_valid),
    .pend_level(pend_level), .vec_base(vec_base), .is_master(is_master),
    .cfg_byte(cfg_byte), .cas_in(cas_in), .commit(commit),
    .commit_lvl(commit_lvl), .data_out(data_out), .data_oe(data_oe),
    .cas_out(cas_out), .cas_oe(cas_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input bit m, input logic [7:0] cfg, input logic [4:0] base,
                         input bit pv, input logic [2:0] lvl, input logic [2:0] cas,
                         input logic [2:0] lvl_later, input int hold);
    @(negedge clk);
    is_master = m; cfg_byte = cfg; vec_base = base;
    pend_valid = pv; pend_level = lvl; cas_in = cas;
    @(negedge clk) iack = 1'b1;
    @(negedge clk);
    o_commit = commit; o_lvl = commit_lvl; o_cas_oe = cas_oe; o_cas = cas_out;
    pend_level = lvl_later; pend_valid = 1'b1;
    o_extra = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      o_extra |= commit;
    end
    iack = 1'b0;
    @(negedge clk);
    @(negedge clk) iack = 1'b1;
    @(negedge clk);
    o_oe = data_oe; o_data = data_out;
    @(negedge clk);
    o_oe_hold = data_oe;
    iack = 1'b0;
    @(negedge clk);
    o_oe_after = data_oe; o_data_after = data_out; o_cas_after = cas_oe;
  endtask

  task automatic t_reset;
    chk(commit == 0 && data_oe == 0 && cas_oe == 0, "R9 reset enables",
        {commit, data_oe, cas_oe}, 0);
    chk(data_out == 0 && commit_lvl == 0 && cas_out == 0, "R9 reset values",
        {data_out, commit_lvl, cas_out}, 0);
  endtask

  task automatic t_master_plain;
    run_seq(1'b1, 8'h04, 5'h01, 1'b1, 3'd3, 3'd0, 3'd3, 1);
    chk(o_commit && o_lvl == 3, "R1 commit level", {o_commit, o_lvl}, {1'b1, 3'd3});
    chk(!o_extra, "R1 single commit", o_extra, 0);
    chk(o_oe && o_data == 8'h0B, "R3 vector 0x0B", o_data, 8'h0B);
    chk(!o_cas_oe && !o_cas_after, "R6 no cascade drive", o_cas_oe, 0);
    chk(o_oe_hold, "R4 oe held during pulse", o_oe_hold, 1);
    chk(!o_oe_after && o_data_after == 0, "R4 released", {o_oe_after, o_data_after}, 0);
  endtask

  task automatic t_default_level;
    run_seq(1'b1, 8'h00, 5'h01, 1'b0, 3'd1, 3'd0, 3'd1, 1);
    chk(o_lvl == 7, "R2 default level", o_lvl, 7);
    chk(o_data == 8'h0F, "R2 default vector", o_data, 8'h0F);
  endtask

  task automatic t_cascade;
    run_seq(1'b1, 8'h04, 5'h01, 1'b1, 3'd2, 3'd0, 3'd2, 1);
    chk(o_cas_oe && o_cas == 3'd2, "R5 cascade id", {o_cas_oe, o_cas}, {1'b1, 3'd2});
    chk(!o_oe && o_data == 0, "R5 master off bus", {o_oe, o_data}, 0);
    chk(!o_cas_after, "R5 cascade released", o_cas_after, 0);
  endtask

  task automatic t_slave_match;
    run_seq(1'b0, 8'h02, 5'h0E, 1'b1, 3'd2, 3'd2, 3'd2, 1);
    chk(o_oe && o_data == 8'h72, "R7 slave vector 0x72", o_data, 8'h72);
    chk(!o_cas_oe, "R7 slave no cascade", o_cas_oe, 0);
  endtask

  task automatic t_slave_miss;
    run_seq(1'b0, 8'h02, 5'h0E, 1'b1, 3'd2, 3'd5, 3'd2, 1);
    chk(!o_oe && o_data == 0, "R8 slave silent", {o_oe, o_data}, 0);
  endtask

  task automatic t_late_change;
    run_seq(1'b1, 8'h00, 5'h01, 1'b1, 3'd3, 3'd0, 3'd6, 4);
    chk(o_lvl == 3, "R10 level at edge", o_lvl, 3);
    chk(!o_extra, "R10 held pulse no recommit", o_extra, 0);
    chk(o_data == 8'h0B, "R10 vector unchanged", o_data, 8'h0B);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iack = 1'b0; pend_valid = 1'b0; pend_level = '0;
    vec_base = '0; is_master = 1'b1; cfg_byte = '0; cas_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_master_plain();
    t_default_level();
    t_cascade();
    t_slave_match();
    t_slave_miss();
    t_late_change();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule